// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

The block is a local interrupt timer. A down-counter runs from a count loaded by software. It advances only on cycles where an external bus-clock enable is high, and a programmable prescaler thins those enables further. When the count runs out, the timer raises an interrupt request. The request carries an 8-bit vector taken from a timer entry register. That register also holds a mask bit and a mode bit. In one-shot mode the counter stops at zero. In periodic mode it reloads and keeps running.

Software reaches the timer through a plain 32-bit register port, with a write strobe and an address select. The read data is combinational on the address. The interrupt request leaves on a valid/ready stream.

The stream follows these rules:
- `irq_valid` stays high, with `irq_vector`, until a cycle in which `irq_ready` is also high.
- Each accepted transfer consumes one recorded expiry.
- Expiries that arrive while the consumer holds off are counted in a small saturating counter, so they are not lost up to its limit.
- Holding `irq_ready` low never stalls the countdown.

Register map. The address is 3 bits wide and any other address reads zero.

| Address | Register | Bits |
|---|---|---|
| 0 | control | bit 0 is the software enable |
| 1 | timer entry | [7:0] vector, bit 8 mask, bit 9 periodic, bit 10 read-only busy |
| 2 | divide configuration | [3:0] |
| 3 | initial count | full width |
| 4 | current count | read-only |

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the timer entry reads 0x100 (masked, vector 0, one-shot). The control, divide configuration, initial count and current count registers all read 0, and `irq_valid` is low.
- R2: The divide ratio is 2^((({cfg[3],cfg[1:0]}) + 1) mod 8). Codes 0,1,2,3,8,9,10,11 select 2,4,8,16,32,64,128,1. cfg[2] has no effect on the ratio.
- R3: The current count drops by exactly one after every D cycles that have `tick_en` high, where D is the divide ratio. While `tick_en` is low it holds its value.
- R4: Writing the initial count abandons any countdown in progress and loads the current count with the written value on the next edge; counting starts again from there. A value of 0 stops the timer, and the current count reads 0.
- R5: In one-shot mode the step from 1 expires the timer. The current count then stays at 0 until the initial count is written again.
- R6: In periodic mode the step from 1 expires the timer and reloads the current count from the initial count, and counting continues.
- R7: An entry write keeps only vector [7:0], mask (bit 8) and periodic (bit 9). Every other written bit is dropped, including bit 10.
- R8: While the software enable is 0, entry writes store the mask bit as 1. Writing 0 to the enable sets the stored mask and discards every recorded expiry.
- R9: An expiry while the entry is unmasked raises `irq_valid`, with `irq_vector` equal to the entry vector. The request is held until it is accepted.
- R10: An expiry while the entry is masked is not recorded. Unmasking afterwards raises no request.
- R11: Recorded expiries are counted up to 2^PEND_W-1, and the count saturates there. Each accepted transfer removes one.
- R12: Entry bit 10 reads 1 exactly while `irq_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick_en | input | 1 | bus-clock enable that feeds the prescaler |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr, combinational |
| irq_valid | output | 1 | interrupt request valid |
| irq_ready | input | 1 | consumer accepts the request |
| irq_vector | output | 8 | vector carried by the request |

## Verification
The hardest state to reach from the ports is saturation of the expiry counter while the consumer holds off. The bench reaches it by holding `irq_ready` low on a short periodic count with divide-by-1, so that several expiries pile up. It then stops the timer with a zero initial count and counts the accepted transfers, which must equal the saturation limit. Masked expiries and expiries discarded by clearing the enable are covered the same way: the bench creates the expiry first, then unmasks or re-enables, and checks that no request appears.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int VEC_W  = 8;
  localparam int PS_W   = 7;   // prescaler counter width: largest ratio is 2^7

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENTRY = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd2;
  localparam logic [ADDR_W-1:0] A_INIT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CUR   = 3'd4;

  localparam int E_MASK = 8;
  localparam int E_PER  = 9;
  localparam int E_BUSY = 10;

  typedef struct packed {
    logic             mask;
    logic             periodic;
    logic [VEC_W-1:0] vector;
  } entry_t;

  // Shift amount of the divide ratio; configuration bit 2 does not take part.
  function automatic logic [2:0] div_shift(input logic [3:0] cfg);
    return {cfg[3], cfg[1:0]} + 3'd1;
  endfunction
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur_count,
  input  logic              req_busy,
  output logic              sw_en,
  output entry_t            entry,
  output logic [3:0]        div_cfg,
  output logic [CNT_W-1:0]  init_count,
  output logic              load,
  output logic              flush,
  output logic [DATA_W-1:0] rdata
);
  assign load  = we && (addr == A_INIT);
  assign flush = we && (addr == A_CTRL) && !wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_en      <= 1'b0;
      entry      <= '{mask: 1'b1, periodic: 1'b0, vector: '0};
      div_cfg    <= 4'd0;
      init_count <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          sw_en <= wdata[0];
          if (!wdata[0]) entry.mask <= 1'b1;
        end
        A_ENTRY: begin
          entry.vector   <= wdata[VEC_W-1:0];
          entry.periodic <= wdata[E_PER];
          entry.mask     <= wdata[E_MASK] | ~sw_en;
        end
        A_DIV:  div_cfg    <= wdata[3:0];
        A_INIT: init_count <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[0] = sw_en;
      A_ENTRY: begin
        rdata[VEC_W-1:0] = entry.vector;
        rdata[E_MASK]    = entry.mask;
        rdata[E_PER]     = entry.periodic;
        rdata[E_BUSY]    = req_busy;
      end
      A_DIV:   rdata[3:0] = div_cfg;
      A_INIT:  rdata = DATA_W'(init_count);
      A_CUR:   rdata = DATA_W'(cur_count);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import irq_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       run,
  input  logic       restart,
  input  logic [3:0] div_cfg,
  output logic       step
);
  logic [PS_W-1:0] pcnt;
  logic [PS_W:0]   span;
  logic [PS_W-1:0] limit;

  assign span  = (PS_W+1)'(1) << div_shift(div_cfg);
  assign limit = PS_W'(span - 1'b1);
  // ">=" keeps the prescaler from stalling if the ratio shrinks mid-count
  assign step  = run && tick_en && (pcnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) pcnt <= '0;
    else if (tick_en)              pcnt <= step ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_value,
  input  logic [CNT_W-1:0] init_count,
  input  logic             step,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur_count,
  output logic             run,
  output logic             expire
);
  assign run    = (cur_count != '0);
  assign expire = step && (cur_count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cur_count <= '0;
    else if (load)   cur_count <= load_value;
    else if (expire) cur_count <= periodic ? init_count : '0;
    else if (step)   cur_count <= cur_count - 1'b1;
  end
endmodule

// File: rtl/timer_pending.sv
module timer_pending #(
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              mask,
  input  logic              flush,
  input  logic              ready,
  output logic              valid,
  output logic [PEND_W-1:0] pend_count
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic record;
  logic take;

  assign valid  = (pend_count != '0) && !mask;
  assign record = expire && !mask;
  assign take   = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) pend_count <= '0;
    else begin
      case ({record, take})
        2'b10:   if (pend_count != PEND_MAX) pend_count <= pend_count + 1'b1;
        2'b01:   pend_count <= pend_count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import irq_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VEC_W-1:0]  irq_vector
);
  logic              sw_en;
  entry_t            entry_q;
  logic [3:0]        div_cfg;
  logic [CNT_W-1:0]  init_count;
  logic              load;
  logic              flush;
  logic [CNT_W-1:0]  cur_count;
  logic              run;
  logic              step;
  logic              expire;
  logic [PEND_W-1:0] pend_count;

  timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cur_count(cur_count), .req_busy(irq_valid), .sw_en(sw_en), .entry(entry_q),
    .div_cfg(div_cfg), .init_count(init_count), .load(load), .flush(flush),
    .rdata(reg_rdata)
  );

  timer_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .restart(load),
    .div_cfg(div_cfg), .step(step)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_value(reg_wdata[CNT_W-1:0]),
    .init_count(init_count), .step(step), .periodic(entry_q.periodic),
    .cur_count(cur_count), .run(run), .expire(expire)
  );

  timer_pending #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .expire(expire), .mask(entry_q.mask),
    .flush(flush), .ready(irq_ready), .valid(irq_valid), .pend_count(pend_count)
  );

  assign irq_vector = entry_q.vector;
endmodule

// File: rtl/irq_timer_checker.sv
module irq_timer_checker
  import irq_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [CNT_W-1:0]  cur_count,
  input logic              sw_en,
  input logic              entry_mask,
  input logic [PEND_W-1:0] pend_count,
  input logic              expire,
  input logic              flush
);
  logic init_wr;
  assign init_wr = reg_we && (reg_addr == A_INIT);

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !init_wr) |=> $stable(cur_count));

  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (cur_count == $past(reg_wdata[CNT_W-1:0])));

  assert_zero_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_count == '0) && !init_wr) |=> (cur_count == '0));

  assert_disabled_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> entry_mask);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !reg_we) |=> irq_valid);

  assert_accept_consumes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !expire && !flush) |=>
      (pend_count == PEND_W'($past(pend_count) - 1'b1)));
endmodule

bind irq_countdown_timer irq_timer_checker #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_valid(irq_valid),
  .irq_ready(irq_ready), .cur_count(cur_count), .sw_en(sw_en),
  .entry_mask(entry_q.mask), .pend_count(pend_count), .expire(expire),
  .flush(flush)
);

// File: tb/irq_countdown_timer_bench.sv
`timescale 1ns/1ps
module irq_countdown_timer_bench;
  import irq_timer_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_en = 1'b1;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq_valid;
  logic              irq_ready = 1'b0;
  logic [VEC_W-1:0]  irq_vector;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_countdown_timer u_irq_countdown_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector)
  );

  typedef struct packed {
    logic [3:0]  cfg;
    logic [15:0] n;
    logic        per;
    logic [7:0]  k;
    logic [15:0] expv;
  } row_t;

  // divide code, initial count, periodic, edges after load, expected current count
  localparam row_t ROWS [12] = '{
    '{4'hB, 16'd10, 1'b0, 8'd3,   16'd7},
    '{4'h0, 16'd10, 1'b0, 8'd5,   16'd8},
    '{4'h1, 16'd5,  1'b0, 8'd9,   16'd3},
    '{4'h8, 16'd3,  1'b0, 8'd64,  16'd1},
    '{4'h4, 16'd6,  1'b0, 8'd7,   16'd3},
    '{4'hB, 16'd4,  1'b0, 8'd10,  16'd0},
    '{4'hB, 16'd4,  1'b1, 8'd6,   16'd2},
    '{4'h0, 16'd3,  1'b1, 8'd8,   16'd2},
    '{4'h2, 16'd2,  1'b0, 8'd15,  16'd1},
    '{4'h3, 16'd2,  1'b0, 8'd16,  16'd1},
    '{4'h9, 16'd2,  1'b0, 8'd64,  16'd1},
    '{4'hA, 16'd1,  1'b0, 8'd127, 16'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_ENTRY, v); check("R1 entry", v, 32'h100);
    rd(A_CTRL, v);  check("R1 ctrl", v, 32'h0);
    rd(A_DIV, v);   check("R1 div", v, 32'h0);
    rd(A_INIT, v);  check("R1 init", v, 32'h0);
    rd(A_CUR, v);   check("R1 cur", v, 32'h0);
    check("R1 valid", 32'(irq_valid), 32'h0);

    // R8 entry write while disabled is stored masked
    wr(A_ENTRY, 32'h2AB);
    rd(A_ENTRY, v); check("R8 forced mask", v, 32'h3AB);

    // R7 dropped bits, bit 10 not writable
    wr(A_CTRL, 32'h1);
    wr(A_ENTRY, 32'hFFFF_FFCD);
    rd(A_ENTRY, v); check("R7 entry fields", v, 32'h3CD);

    // R2/R3/R6 table walk
    irq_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      wr(A_ENTRY, 32'(ROWS[i].per) << 9 | 32'h11);
      wr(A_DIV, 32'(ROWS[i].cfg));
      wr(A_INIT, 32'(ROWS[i].n));
      repeat (int'(ROWS[i].k)) @(negedge clk);
      rd(A_CUR, v);
      check(ROWS[i].per ? "R6 periodic count" : "R2 divide count", v, 32'(ROWS[i].expv));
    end

    // R3 tick enable gating
    wr(A_ENTRY, 32'h011);
    wr(A_DIV, 32'hB);
    wr(A_INIT, 32'd10);
    tick_en = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_CUR, v); check("R3 hold without tick", v, 32'd10);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_CUR, v); check("R3 count with tick", v, 32'd7);

    // R4 restart and stop
    wr(A_INIT, 32'd8);
    repeat (2) @(negedge clk);
    rd(A_CUR, v); check("R4 restart", v, 32'd6);
    irq_ready = 1'b0;
    wr(A_INIT, 32'd0);
    repeat (20) @(negedge clk);
    rd(A_CUR, v); check("R4 zero stops", v, 32'd0);
    check("R4 no expiry", 32'(irq_valid), 32'h0);

    // R9/R12/R5 one-shot expiry
    wr(A_ENTRY, 32'h05A);
    wr(A_INIT, 32'd3);
    repeat (2) @(negedge clk);
    check("R9 not yet", 32'(irq_valid), 32'h0);
    @(negedge clk);
    check("R9 valid", 32'(irq_valid), 32'h1);
    check("R9 vector", 32'(irq_vector), 32'h5A);
    rd(A_ENTRY, v); check("R12 busy bit", v, 32'h45A);
    repeat (7) @(negedge clk);
    rd(A_CUR, v); check("R5 sticks at zero", v, 32'd0);
    check("R9 held", 32'(irq_valid), 32'h1);
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
    check("R11 accepted", 32'(irq_valid), 32'h0);
    rd(A_ENTRY, v); check("R12 busy clear", v, 32'h05A);

    // R11 saturation under back-pressure
    wr(A_ENTRY, 32'h25A);
    wr(A_INIT, 32'd2);
    repeat (10) @(negedge clk);
    wr(A_INIT, 32'd0);
    irq_ready = 1'b1;
    acc = 0;
    for (int i = 0; i < 8; i++) begin
      if (irq_valid) acc++;
      @(negedge clk);
    end
    irq_ready = 1'b0;
    check("R11 saturated count", 32'(acc), 32'd3);

    // R10 masked expiry not recorded
    wr(A_ENTRY, 32'h15A);
    wr(A_INIT, 32'd2);
    repeat (5) @(negedge clk);
    check("R10 masked", 32'(irq_valid), 32'h0);
    wr(A_ENTRY, 32'h05A);
    check("R10 after unmask", 32'(irq_valid), 32'h0);

    // R8 clearing enable discards pending
    wr(A_INIT, 32'd1);
    repeat (2) @(negedge clk);
    check("R8 pending before", 32'(irq_valid), 32'h1);
    wr(A_CTRL, 32'h0);
    check("R8 disabled", 32'(irq_valid), 32'h0);
    rd(A_ENTRY, v); check("R8 mask set", v, 32'h15A);
    wr(A_CTRL, 32'h1);
    wr(A_ENTRY, 32'h05A);
    check("R8 discarded", 32'(irq_valid), 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule